// File: doc/BRIEF.md
# Programmable-Flag Offset Loader

This block keeps the two threshold registers a FIFO's almost-empty and almost-full flag logic compares against. `empty_ofs` is the distance from empty and `full_ofs` is the distance from full. While master reset is held, the block samples the load-select pin and a two-bit preset selector. From them it fixes the programming method for the whole session and loads one preset value into both registers.

After reset, a shared decode of the load-select pin and the active-low write, read and shift enables steers each clock cycle to one of two places:

- **The FIFO memory.** The block raises a write or read strobe for the memory.
- **The offset registers.** These can be written as four half-register bus steps or as a serial bit stream on the write clock. They can be read back as four half-register steps on the read clock.

The memory array and the flag comparators sit outside this block.

Top module: `flag_offset_loader`

## Requirements
- R1: The `ld` level sampled while `mrs_n` is low fixes the programming method until the next master reset. `ld`=1 selects serial shifting and `ld`=0 selects parallel bus writes.
- R2: While `mrs_n` is low, both offsets load 2^e-1, where AW=log2(DEPTH). The exponent e depends on {`ld`,`fsel[1]`,`fsel[0]`]:
  - 010 gives e=AW-1.
  - 001 gives e=AW-2.
  - 000 gives e=AW-3.
  - 011 gives e=AW-4.
  - 100 gives e=AW-5.
  - 110 gives e=AW-6.
  - 101 gives e=AW-7.
  - 111 gives e=AW-8.

  For DEPTH=1024 the values are 511, 255, 127, 63, 31, 15, 7 and 3. The `ld` and `fsel` pins must stay stable for two write-clock edges after `mrs_n` rises.
- R3: In parallel mode, each write-clock edge with `ld`=0 and `wen_n`=0 stores the bus low bits into the next of four steps, in this order:
  1. Empty low half (bits [LO_W-1:0], LO_W=ceil(AW/2)).
  2. Empty high half.
  3. Full low half.
  4. Full high half.

  Each high-half step takes `d[HI_W-1:0]` with HI_W=AW-LO_W. The step pointer wraps after step 4.
- R4: In serial mode, a cycle with `ld`=0 and `wen_n`=0 leaves both offsets unchanged.
- R5: In serial mode, each write-clock edge with `ld`=0, `wen_n`=1, `ren_n`=1 and `sen_n`=0 shifts `sdin` in. After 2*AW shifts, the first bit shifted sits in the empty LSB and the last in the full MSB.
- R6: In parallel mode, shift cycles leave both offsets unchanged.
- R7: Each read-clock edge with `ld`=0 and `ren_n`=0 puts the next of the same four halves on `q`, zero-extended. The step pointer wraps after step 4. This works in both programming methods.
- R8: With `ld`=1, `mem_we` equals `~wen_n` and `mem_re` equals `~ren_n`. Neither offset, nor `q`, nor either step pointer changes.
- R9: With `ld`=0 and `wen_n`, `ren_n` and `sen_n` all high, the offsets and `q` hold.
- R10: Master reset returns both step pointers to step 1 and clears `q` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrs_n | input | 1 | Master reset, active low, asynchronous assert |
| ld | input | 1 | Load select: 1 routes enables to memory, 0 to offsets; sampled in reset as method |
| fsel | input | 2 | Preset selector sampled in reset |
| wen_n | input | 1 | Write enable, active low |
| ren_n | input | 1 | Read enable, active low |
| sen_n | input | 1 | Serial shift enable, active low |
| sdin | input | 1 | Serial data bit |
| d | input | DW | Parallel data bus |
| empty_ofs | output | AW | Empty offset (n) |
| full_ofs | output | AW | Full offset (m) |
| q | output | DW | Offset readback bus |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |

## Verification
The assertions assume the following about the inputs:
- `ld` and the three enables change only away from rising clock edges.
- The preset pins stay stable from reset until two write-clock edges after release.
- Offsets are not rewritten while a readback on the read clock samples them, because the registers cross into the read domain unsynchronised.

The stimulus respects all three. It drives every input on the falling edge, holds the reset-time pins for three cycles after `mrs_n` rises, and never overlaps a parallel write with a readback.

// File: rtl/ofsld_pkg.sv
package ofsld_pkg;

  // Half-register step order shared by the write and read sequencers
  typedef enum logic [1:0] {
    STEP_E_LO = 2'd0,
    STEP_E_HI = 2'd1,
    STEP_F_LO = 2'd2,
    STEP_F_HI = 2'd3
  } step_e;

  // Exponent of the preset (value = 2^e - 1) picked by {ld, fsel}
  function automatic int preset_exp(input logic ld, input logic [1:0] fsel, input int aw);
    int e;
    case ({ld, fsel})
      3'b010:  e = aw - 1;
      3'b001:  e = aw - 2;
      3'b000:  e = aw - 3;
      3'b011:  e = aw - 4;
      3'b100:  e = aw - 5;
      3'b110:  e = aw - 6;
      3'b101:  e = aw - 7;
      default: e = aw - 8;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/ofsld_rst_sync.sv
module ofsld_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n = s2_q;
endmodule

// File: rtl/ofsld_wr.sv
module ofsld_wr
  import ofsld_pkg::*;
#(
  parameter int AW   = 10,
  parameter int LO_W = (AW + 1) / 2
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [1:0]    fsel,
  input  logic          wen_n,
  input  logic          ren_n,
  input  logic          sen_n,
  input  logic          sdin,
  input  logic [LO_W-1:0] d_part,
  output logic [AW-1:0] empty_ofs,
  output logic [AW-1:0] full_ofs,
  output logic          ser_mode,
  output logic [1:0]    wr_step
);
  localparam int HI_W = AW - LO_W;

  logic [AW-1:0]   n_q, n_d, m_q, m_d, dflt;
  logic [2*AW-1:0] both;
  logic            ser_q;
  step_e           step_q, step_d;
  logic            par_wr, shift, ofs_en;
  int              e;

  assign par_wr = !ld && !wen_n && !ser_q;
  assign shift  = !ld && wen_n && ren_n && !sen_n && ser_q;
  assign ofs_en = !rst_n || par_wr || shift;

  always_comb begin
    e    = preset_exp(ld, fsel, AW);
    dflt = ~({AW{1'b1}} << e);
  end

  // next-state
  always_comb begin
    n_d    = n_q;
    m_d    = m_q;
    step_d = step_q;
    both   = {m_q, n_q};
    if (!rst_n) begin
      n_d = dflt;
      m_d = dflt;
    end else if (par_wr) begin
      step_d = step_e'(step_q + 2'd1);
      case (step_q)
        STEP_E_LO: n_d[LO_W-1:0]  = d_part;
        STEP_E_HI: n_d[AW-1:LO_W] = d_part[HI_W-1:0];
        STEP_F_LO: m_d[LO_W-1:0]  = d_part;
        default:   m_d[AW-1:LO_W] = d_part[HI_W-1:0];
      endcase
    end else if (shift) begin
      {m_d, n_d} = {sdin, both[2*AW-1:1]};
    end
  end

  // offset and mode registers: loaded from pins while reset is held
  always_ff @(posedge wclk) begin
    if (ofs_en) begin
      n_q <= n_d;
      m_q <= m_d;
    end
    if (!rst_n) ser_q <= ld;
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n)      step_q <= STEP_E_LO;
    else if (par_wr) step_q <= step_d;
  end

  assign empty_ofs = n_q;
  assign full_ofs  = m_q;
  assign ser_mode  = ser_q;
  assign wr_step   = step_q;
endmodule

// File: rtl/ofsld_rd.sv
module ofsld_rd
  import ofsld_pkg::*;
#(
  parameter int AW   = 10,
  parameter int DW   = 36,
  parameter int LO_W = (AW + 1) / 2
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic          ren_n,
  input  logic [AW-1:0] empty_ofs,
  input  logic [AW-1:0] full_ofs,
  output logic [DW-1:0] q,
  output logic [1:0]    rd_step
);
  localparam int HI_W = AW - LO_W;

  step_e         step_q;
  logic [DW-1:0] q_q, q_d;
  logic          rd_en;

  assign rd_en = !ld && !ren_n;

  always_comb begin
    q_d = '0;
    case (step_q)
      STEP_E_LO: q_d[LO_W-1:0] = empty_ofs[LO_W-1:0];
      STEP_E_HI: q_d[HI_W-1:0] = empty_ofs[AW-1:LO_W];
      STEP_F_LO: q_d[LO_W-1:0] = full_ofs[LO_W-1:0];
      default:   q_d[HI_W-1:0] = full_ofs[AW-1:LO_W];
    endcase
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= STEP_E_LO;
      q_q    <= '0;
    end else if (rd_en) begin
      step_q <= step_e'(step_q + 2'd1);
      q_q    <= q_d;
    end
  end

  assign q       = q_q;
  assign rd_step = step_q;
endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader #(
  parameter int DEPTH = 1024,  // power of two, at least 512
  parameter int DW    = 36
) (
  input  logic                     wclk,
  input  logic                     rclk,
  input  logic                     mrs_n,
  input  logic                     ld,
  input  logic [1:0]               fsel,
  input  logic                     wen_n,
  input  logic                     ren_n,
  input  logic                     sen_n,
  input  logic                     sdin,
  input  logic [DW-1:0]            d,
  output logic [$clog2(DEPTH)-1:0] empty_ofs,
  output logic [$clog2(DEPTH)-1:0] full_ofs,
  output logic [DW-1:0]            q,
  output logic                     mem_we,
  output logic                     mem_re
);
  localparam int AW   = $clog2(DEPTH);
  localparam int LO_W = (AW + 1) / 2;

  logic       rst_w_n, rst_r_n, ser_mode;
  logic [1:0] wr_step, rd_step;
  logic       unused_d_hi;

  assign unused_d_hi = ^d[DW-1:LO_W];

  ofsld_rst_sync u_rst_w (.clk(wclk), .arst_n(mrs_n), .rst_n(rst_w_n));
  ofsld_rst_sync u_rst_r (.clk(rclk), .arst_n(mrs_n), .rst_n(rst_r_n));

  ofsld_wr #(.AW(AW), .LO_W(LO_W)) u_wr (
    .wclk(wclk), .rst_n(rst_w_n), .ld(ld), .fsel(fsel),
    .wen_n(wen_n), .ren_n(ren_n), .sen_n(sen_n), .sdin(sdin),
    .d_part(d[LO_W-1:0]), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
    .ser_mode(ser_mode), .wr_step(wr_step)
  );

  ofsld_rd #(.AW(AW), .DW(DW), .LO_W(LO_W)) u_rd (
    .rclk(rclk), .rst_n(rst_r_n), .ld(ld), .ren_n(ren_n),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs), .q(q), .rd_step(rd_step)
  );

  // shared decode: LD high hands the enables to the memory
  assign mem_we = ld && !wen_n;
  assign mem_re = ld && !ren_n;
endmodule

// File: rtl/flag_offset_loader_chk.sv
module flag_offset_loader_chk #(
  parameter int AW = 10,
  parameter int DW = 36
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_w_n,
  input logic          rst_r_n,
  input logic          ld,
  input logic          wen_n,
  input logic          ren_n,
  input logic          sen_n,
  input logic          sdin,
  input logic [DW-1:0] d,
  input logic [AW-1:0] empty_ofs,
  input logic [AW-1:0] full_ofs,
  input logic [DW-1:0] q,
  input logic          ser_mode,
  input logic [1:0]    wr_step,
  input logic [1:0]    rd_step
);
  localparam int LO_W = (AW + 1) / 2;

  // R9
  idle_hold_chk: assert property (@(posedge wclk) disable iff (!rst_w_n)
    (ld || (wen_n && sen_n)) |=> ($stable(empty_ofs) && $stable(full_ofs)));

  // R4
  ser_nopar_chk: assert property (@(posedge wclk) disable iff (!rst_w_n)
    (ser_mode && !ld && !wen_n) |=> ($stable(empty_ofs) && $stable(full_ofs)));

  // R3
  par_lo_chk: assert property (@(posedge wclk) disable iff (!rst_w_n)
    (!ser_mode && !ld && !wen_n && wr_step == 2'd0)
    |=> (empty_ofs[LO_W-1:0] == $past(d[LO_W-1:0]) && $stable(full_ofs)));

  // R3
  par_step_chk: assert property (@(posedge wclk) disable iff (!rst_w_n)
    (!ser_mode && !ld && !wen_n) |=> (wr_step == 2'($past(wr_step) + 2'd1)));

  // R5
  shift_chk: assert property (@(posedge wclk) disable iff (!rst_w_n)
    (ser_mode && !ld && wen_n && ren_n && !sen_n)
    |=> (full_ofs[AW-1] == $past(sdin) && empty_ofs[AW-2:0] == $past(empty_ofs[AW-1:1])));

  // R6
  par_noshift_chk: assert property (@(posedge wclk) disable iff (!rst_w_n)
    (!ser_mode && !ld && wen_n && !sen_n) |=> ($stable(empty_ofs) && $stable(full_ofs)));

  // R7
  rd_lo_chk: assert property (@(posedge rclk) disable iff (!rst_r_n)
    (!ld && !ren_n && rd_step == 2'd0)
    |=> (q[LO_W-1:0] == $past(empty_ofs[LO_W-1:0]) && q[DW-1:LO_W] == '0));

  // R8
  rd_hold_chk: assert property (@(posedge rclk) disable iff (!rst_r_n)
    ld |=> ($stable(q) && $stable(rd_step)));
endmodule

bind flag_offset_loader flag_offset_loader_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/flag_offset_loader_tb.sv
`timescale 1ns/1ps
module flag_offset_loader_tb;
  localparam int DEPTH = 1024;
  localparam int DW    = 36;
  localparam int AW    = 10;
  localparam int LO_W  = 5;

  // {full, empty} pairs for the parallel write/readback walk
  localparam logic [19:0] VEC [6] = '{
    {10'd0,    10'd1023},
    {10'd1023, 10'd0},
    {10'h2AA,  10'h155},
    {10'd5,    10'd900},
    {10'd511,  10'd512},
    {10'h0F0,  10'h30F}
  };

  logic wclk = 1'b0, rclk = 1'b0;
  logic mrs_n = 1'b0, ld = 1'b0, wen_n = 1'b1, ren_n = 1'b1, sen_n = 1'b1, sdin = 1'b0;
  logic [1:0]    fsel = 2'b00;
  logic [DW-1:0] d = '0;
  logic [AW-1:0] empty_ofs, full_ofs;
  logic [DW-1:0] q;
  logic          mem_we, mem_re;
  int checks = 0, errors = 0;

  always #2.5 begin wclk = ~wclk; rclk = ~rclk; end

  flag_offset_loader #(.DEPTH(DEPTH), .DW(DW)) u_dut (
    .wclk(wclk), .rclk(rclk), .mrs_n(mrs_n), .ld(ld), .fsel(fsel),
    .wen_n(wen_n), .ren_n(ren_n), .sen_n(sen_n), .sdin(sdin), .d(d),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs), .q(q),
    .mem_we(mem_we), .mem_re(mem_re)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge wclk);
    @(negedge wclk);
  endtask

  task automatic do_reset(input logic l, input logic [1:0] fs);
    mrs_n = 1'b0; ld = l; fsel = fs; wen_n = 1'b1; ren_n = 1'b1; sen_n = 1'b1;
    repeat (3) tick();
    mrs_n = 1'b1;
    repeat (3) tick();
    ld = 1'b0;
  endtask

  task automatic pwrite(input logic [LO_W-1:0] part);
    ld = 1'b0; wen_n = 1'b0; d = {31'h2BADF00D, part};
    tick();
    wen_n = 1'b1;
  endtask

  task automatic pread(output logic [DW-1:0] v);
    ld = 1'b0; ren_n = 1'b0;
    tick();
    v = q;
    ren_n = 1'b1;
  endtask

  task automatic shift1(input logic b);
    ld = 1'b0; sen_n = 1'b0; sdin = b;
    tick();
    sen_n = 1'b1;
  endtask

  function automatic logic [AW-1:0] preset_val(input logic l, input logic [1:0] fs);
    case ({l, fs})
      3'b010:  return 10'd511;
      3'b001:  return 10'd255;
      3'b000:  return 10'd127;
      3'b011:  return 10'd63;
      3'b100:  return 10'd31;
      3'b110:  return 10'd15;
      3'b101:  return 10'd7;
      default: return 10'd3;
    endcase
  endfunction

  task automatic read_all(input logic [AW-1:0] n, input logic [AW-1:0] m, input string req);
    logic [DW-1:0] v;
    pread(v); check(req, v, 64'(n[4:0]));
    pread(v); check(req, v, 64'(n[9:5]));
    pread(v); check(req, v, 64'(m[4:0]));
    pread(v); check(req, v, 64'(m[9:5]));
  endtask

  initial begin
    repeat (50000) @(posedge wclk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] n_exp, m_exp;
    logic [DW-1:0] v;
    logic [19:0]   pat;

    // R2 every preset, R10 reset state of q
    for (int i = 0; i < 8; i++) begin
      do_reset(i[2], i[1:0]);
      check("R2 empty preset", 64'(empty_ofs), 64'(preset_val(i[2], i[1:0])));
      check("R2 full preset", 64'(full_ofs), 64'(preset_val(i[2], i[1:0])));
      check("R10 q cleared", 64'(q), 64'd0);
    end

    // R3 / R7 table walk in parallel mode
    do_reset(1'b0, 2'b00);
    for (int k = 0; k < 6; k++) begin
      n_exp = VEC[k][9:0];
      m_exp = VEC[k][19:10];
      pwrite(n_exp[4:0]); pwrite(n_exp[9:5]); pwrite(m_exp[4:0]); pwrite(m_exp[9:5]);
      check("R3 empty", 64'(empty_ofs), 64'(n_exp));
      check("R3 full", 64'(full_ofs), 64'(m_exp));
      read_all(n_exp, m_exp, "R7 readback parallel");
    end

    // R6 and R1: shifting ignored in parallel mode
    for (int b = 0; b < 20; b++) shift1(1'b1);
    check("R6 empty", 64'(empty_ofs), 64'(n_exp));
    check("R1 R6 full", 64'(full_ofs), 64'(m_exp));

    // R8: LD high goes to memory only
    ld = 1'b1; wen_n = 1'b0; #1;
    check("R8 mem_we", 64'(mem_we), 64'd1);
    tick();
    wen_n = 1'b1; ren_n = 1'b0; #1;
    check("R8 mem_re", 64'(mem_re), 64'd1);
    tick();
    ren_n = 1'b1;
    check("R8 offsets", 64'({full_ofs, empty_ofs}), 64'({m_exp, n_exp}));
    check("R8 q", 64'(q), 64'(m_exp[9:5]));
    pwrite(5'd17);
    n_exp = {n_exp[9:5], 5'd17};
    check("R8 write pointer unmoved", 64'(empty_ofs), 64'(n_exp));
    pread(v);
    check("R8 read pointer unmoved", 64'(v), 64'd17);

    // R9: idle
    ld = 1'b0;
    repeat (3) tick();
    check("R9 offsets", 64'({full_ofs, empty_ofs}), 64'({m_exp, n_exp}));
    check("R9 q", 64'(q), 64'd17);
    check("R9 mem_we", 64'(mem_we), 64'd0);

    // R10: pointers restart after reset (both are at step 2 now)
    do_reset(1'b0, 2'b11);
    pwrite(5'd9);
    check("R10 write step", 64'(empty_ofs), 64'(10'd41));
    pread(v);
    check("R10 read step", 64'(v), 64'd9);

    // R1 / R5 serial mode
    do_reset(1'b1, 2'b00);
    pat = {10'h2C7, 10'h13A};
    for (int b = 0; b < 20; b++) shift1(pat[b]);
    check("R5 empty", 64'(empty_ofs), 64'(10'h13A));
    check("R1 R5 full", 64'(full_ofs), 64'(10'h2C7));

    // R4 parallel write ignored in serial mode
    pwrite(5'd0); pwrite(5'd0);
    check("R4 offsets", 64'({full_ofs, empty_ofs}), 64'(pat));

    // R7 readback works in serial mode, with wrap
    read_all(10'h13A, 10'h2C7, "R7 readback serial");
    pread(v);
    check("R7 wrap", 64'(v), 64'(5'h1A));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule